// File: doc/BRIEF.md
# Programmable-Logic Configuration Sequencer

This controller steers a small programmable-logic target through its configuration life cycle. A power-on reset or a low level on the active-low program request starts the sequence. The controller first holds the target in an initiation state. It then clears configuration memory for a fixed number of cycles, keeping the INIT line low throughout. When INIT rises, the controller latches the 3-bit mode input. Frames are then loaded in the way that mode dictates, and a start-up step follows that releases the global I/O tristate and raises DONE.

Frame loading is modelled as a count of bits. In master serial mode the controller drives its own configuration clock and takes one bit per rising edge. In the two slave modes an external clock is synchronised and counted: eight bits per edge on the parallel path, one bit per edge on the serial path. In boundary-scan mode the clock is ignored and the controller waits for an external load-complete strobe.

The state machine has five states: `ST_INIT` (initiation), `ST_CLEAR` (memory clear), `ST_LOAD` (frame load), `ST_RELEASE` (tristate release) and `ST_USER` (user operation). Its transitions are:
- power-on, or a low program request from any state, goes to `ST_INIT`;
- `ST_INIT` goes to `ST_CLEAR` once the program request is high;
- `ST_CLEAR` goes to `ST_LOAD` after the last clear cycle;
- `ST_LOAD` goes to `ST_RELEASE` when the frame count is full, or on the strobe in boundary-scan mode;
- `ST_RELEASE` goes to `ST_USER` after one cycle.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While reset is held, and in `ST_INIT`, the outputs are `done`=0, `init_n`=0, `io_hiz`=1, `pullup_en`=0, `cclk_drive`=0 and `ser_dout`=0.
- R2: After `prog_n` is high in `ST_INIT`, `init_n` stays low for exactly CLEAR_CYCLES (default 16) clock cycles and then rises, and frame loading begins.
- R3: `mode_pins` (M2 M1 M0) are sampled only at the rising edge of `init_n`, with this decode on M1 M0: 00 master serial, 10 slave parallel, 01 boundary scan, 11 slave serial. Changes to `mode_pins` after that edge have no effect until the next configuration.
- R4: In master serial mode, `cclk_drive`=1 during loading and `cclk_out` toggles every clock cycle. Each rising edge of `cclk_out` counts one bit, and loading ends once FRAME_BITS (default 64) bits are counted.
- R5: In slave parallel mode, `cclk_drive`=0. Each synchronised rising edge of `cclk_in` counts 8 bits, so the default frame ends on the 8th edge and not before.
- R6: In slave serial mode, each rising edge of `cclk_in` counts 1 bit. During loading in either serial mode, `ser_dout` follows `ser_din`; in all other cases `ser_dout`=0.
- R7: In boundary-scan mode, `cclk_in` edges are ignored and loading ends only on a high `scan_load_done` sample.
- R8: When M2 XOR M0 = 1 at the sample point, `pullup_en`=1 from the `init_n` rise until the tristate release. When M2 XOR M0 = 0, `pullup_en` stays 0.
- R9: `io_hiz` stays 1 until loading ends. The controller then spends one cycle with `io_hiz`=0 and `done`=0, after which `done`=1.
- R10: A low `prog_n` during user operation drops `done` on the next clock edge and drives `init_n` low; a fresh memory clear follows when `prog_n` returns high.
- R11: A low `prog_n` during frame loading aborts the load, and the next configuration counts its frame from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| prog_n | input | 1 | Active-low program (reconfigure) request |
| mode_pins | input | 3 | Configuration mode select, M2 M1 M0 |
| cclk_in | input | 1 | External configuration clock for the slave modes |
| ser_din | input | 1 | Serial data in |
| scan_load_done | input | 1 | Load-complete strobe used in boundary-scan mode |
| done | output | 1 | High in user operation |
| init_n | output | 1 | Low during initiation and memory clear |
| cclk_drive | output | 1 | 1 when the controller drives the configuration clock |
| cclk_out | output | 1 | Generated configuration clock in master serial mode |
| io_hiz | output | 1 | 1 keeps user I/O high-impedance |
| pullup_en | output | 1 | Pre-configuration pull-up enable |
| ser_dout | output | 1 | Serial data out in the serial modes |

## Verification
All four modes are tried. Master serial shows that the self-generated clock does the counting. Slave parallel and slave serial differ only in bits per edge, so a frame that must not finish early tells the 8-bit path from the 1-bit one. Boundary scan is run with clock edges that must be ignored, followed by the strobe. A pull-up mode is combined with a change of the mode pins during loading to separate the latched mode from the live pins. Program requests in user operation and in the middle of a load show that the sequence acknowledges the request and that the frame count starts again.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [1:0] {
        MODE_MSER  = 2'd0,
        MODE_SPAR  = 2'd1,
        MODE_BSCAN = 2'd2,
        MODE_SSER  = 2'd3
    } cfg_mode_e;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_CLEAR   = 3'd1,
        ST_LOAD    = 3'd2,
        ST_RELEASE = 3'd3,
        ST_USER    = 3'd4
    } cfg_state_e;

    localparam int unsigned PAR_BITS = 8;

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
    import cfg_seq_pkg::*;
(
    input  logic [2:0] pins,
    output cfg_mode_e  mode,
    output logic       pull_up
);
    // M1 M0 choose the mode; M2 flips the pull-up choice per mode
    always_comb begin
        unique case (pins[1:0])
            2'b00:   mode = MODE_MSER;
            2'b10:   mode = MODE_SPAR;
            2'b01:   mode = MODE_BSCAN;
            default: mode = MODE_SSER;
        endcase
        pull_up = pins[2] ^ pins[0];
    end
endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh[0] <= 1'b0;
                else        sh[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh[i] <= 1'b0;
                else        sh[i] <= sh[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sh[STAGES-1];
    end

    assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/cfg_frame_counter.sv
module cfg_frame_counter #(
    parameter int unsigned FRAME_BITS = 64,
    parameter int unsigned INC_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             evt,
    input  logic [INC_W-1:0] inc,
    output logic             full
);
    localparam int unsigned CW = $clog2(FRAME_BITS + (1 << INC_W)) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] sum;

    assign sum  = cnt + CW'(inc);
    assign full = active && evt && (sum >= CW'(FRAME_BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!active) cnt <= '0;
        else if (evt)    cnt <= sum;
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int unsigned CLEAR_CYCLES = 16,
    parameter int unsigned FRAME_BITS   = 64,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_n,
    input  logic [2:0] mode_pins,
    input  logic       cclk_in,
    input  logic       ser_din,
    input  logic       scan_load_done,
    output logic       done,
    output logic       init_n,
    output logic       cclk_drive,
    output logic       cclk_out,
    output logic       io_hiz,
    output logic       pullup_en,
    output logic       ser_dout
);
    localparam int unsigned CLR_W = $clog2(CLEAR_CYCLES + 1);
    localparam int unsigned INC_W = $clog2(PAR_BITS + 1);

    cfg_state_e state, state_nx;
    cfg_mode_e  dec_mode, mode_q;
    logic       dec_pu, pu_q;
    logic [CLR_W-1:0] clr_cnt;
    logic       clr_last;
    logic       cclk_q;
    logic       ext_rise;
    logic       bit_evt;
    logic [INC_W-1:0] bit_inc;
    logic       frame_full;
    logic       loading;

    cfg_mode_decode i_dec (
        .pins    (mode_pins),
        .mode    (dec_mode),
        .pull_up (dec_pu)
    );

    cfg_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cclk_in),
        .rise  (ext_rise)
    );

    assign loading  = (state == ST_LOAD);
    assign clr_last = (clr_cnt == CLR_W'(CLEAR_CYCLES - 1));

    always_comb begin
        unique case (mode_q)
            MODE_MSER:  bit_evt = loading && !cclk_q;
            MODE_SPAR:  bit_evt = ext_rise;
            MODE_SSER:  bit_evt = ext_rise;
            default:    bit_evt = 1'b0;
        endcase
        bit_inc = (mode_q == MODE_SPAR) ? INC_W'(PAR_BITS) : INC_W'(1);
    end

    cfg_frame_counter #(.FRAME_BITS(FRAME_BITS), .INC_W(INC_W)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (loading),
        .evt    (bit_evt),
        .inc    (bit_inc),
        .full   (frame_full)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!prog_n) begin
            state_nx = ST_INIT;
        end else begin
            unique case (state)
                ST_INIT:    state_nx = ST_CLEAR;
                ST_CLEAR:   if (clr_last) state_nx = ST_LOAD;
                ST_LOAD: begin
                    if (mode_q == MODE_BSCAN) begin
                        if (scan_load_done) state_nx = ST_RELEASE;
                    end else if (frame_full) begin
                        state_nx = ST_RELEASE;
                    end
                end
                ST_RELEASE: state_nx = ST_USER;
                ST_USER:    state_nx = ST_USER;
                default:    state_nx = ST_INIT;
            endcase
        end
    end

    // clear timer, mode sample at INIT rise, master clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_cnt <= '0;
            mode_q  <= MODE_MSER;
            pu_q    <= 1'b0;
            cclk_q  <= 1'b0;
        end else begin
            if (state == ST_CLEAR) clr_cnt <= clr_cnt + 1'b1;
            else                   clr_cnt <= '0;
            if (state == ST_CLEAR && clr_last && prog_n) begin
                mode_q <= dec_mode;
                pu_q   <= dec_pu;
            end
            if (loading && mode_q == MODE_MSER && prog_n) cclk_q <= ~cclk_q;
            else                                          cclk_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        done       = 1'b0;
        init_n     = 1'b1;
        io_hiz     = 1'b1;
        pullup_en  = 1'b0;
        cclk_drive = 1'b0;
        cclk_out   = 1'b0;
        ser_dout   = 1'b0;
        unique case (state)
            ST_INIT, ST_CLEAR: init_n = 1'b0;
            ST_LOAD: begin
                pullup_en  = pu_q;
                cclk_drive = (mode_q == MODE_MSER);
                cclk_out   = (mode_q == MODE_MSER) && cclk_q;
                ser_dout   = (mode_q == MODE_MSER || mode_q == MODE_SSER) && ser_din;
            end
            ST_RELEASE: io_hiz = 1'b0;
            ST_USER: begin
                io_hiz = 1'b0;
                done   = 1'b1;
            end
            default: init_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_seq_ctrl_chk.sv
module cfg_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_n,
    input logic done,
    input logic init_n,
    input logic cclk_drive,
    input logic io_hiz,
    input logic pullup_en
);
    // R9: DONE only after the tristate release
    a_r9_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !io_hiz);

    // R9: DONE holds while no program request arrives
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done && prog_n |=> done);

    // R10: a program request drops DONE on the next edge
    a_r10_prog_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> !done && !init_n);

    // R8: pull-ups only between INIT rise and tristate release
    a_r8_pullup_window: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> io_hiz && init_n);

    // R2: nothing drives the clock or signals done while INIT is low
    a_r2_init_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> !done && !cclk_drive && !pullup_en && io_hiz);

    // R4: clock driven only during loading
    a_r4_cclk_drive_load: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_drive |-> init_n && io_hiz && !done);
endmodule

bind cfg_seq_ctrl cfg_seq_ctrl_chk i_chk (.*);

// File: tb/test_cfg_seq_ctrl.sv
module test_cfg_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_n = 1'b0;
    logic [2:0] mode_pins = 3'b000;
    logic       cclk_in = 1'b0;
    logic       ser_din = 1'b0;
    logic       scan_load_done = 1'b0;
    logic       done, init_n, cclk_drive, cclk_out, io_hiz, pullup_en, ser_dout;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    cfg_seq_ctrl i_cfg_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode_pins(mode_pins),
        .cclk_in(cclk_in), .ser_din(ser_din), .scan_load_done(scan_load_done),
        .done(done), .init_n(init_n), .cclk_drive(cclk_drive), .cclk_out(cclk_out),
        .io_hiz(io_hiz), .pullup_en(pullup_en), .ser_dout(ser_dout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pulse program request, release it, wait for INIT to rise
    task automatic start_cfg(input logic [2:0] m);
        @(negedge clk);
        mode_pins = m;
        prog_n = 1'b0;
        cyc(2);
        prog_n = 1'b1;
        for (int i = 0; i < 100 && !init_n; i++) cyc(1);
        cyc(1);
        while (!init_n) cyc(1);
    endtask

    task automatic pulse_cclk();
        cclk_in = 1'b1; cyc(3);
        cclk_in = 1'b0; cyc(3);
    endtask

    task automatic wait_done(input int max, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < max; i++) begin
            if (done) begin seen = 1'b1; break; end
            cyc(1);
        end
    endtask

    task automatic t_reset();
        cyc(2);
        chk(!done && !init_n && io_hiz && !pullup_en && !cclk_drive && !ser_dout,
            "R1 reset outputs", {done, init_n, io_hiz, pullup_en, cclk_drive}, 6'b001000);
        rst_n = 1'b1;
        cyc(3);
        chk(!init_n && !done && io_hiz, "R1 held by prog_n low", init_n, 0);
    endtask

    task automatic t_clear_len();
        int lows;
        mode_pins = 3'b100;   // master serial with pull-ups
        prog_n = 1'b1;
        lows = 0;
        cyc(1);
        while (!init_n && lows < 100) begin lows++; cyc(1); end
        chk(lows == 16, "R2 clear length", lows, 16);
        chk(pullup_en == 1'b1, "R8 pull-up after init rise", pullup_en, 1);
    endtask

    task automatic t_master_serial();
        bit seen;
        int rises;
        logic last;
        rises = 0;
        last = cclk_out;
        chk(cclk_drive == 1'b1, "R4 clock driven", cclk_drive, 1);
        ser_din = 1'b1; #1;
        chk(ser_dout == 1'b1, "R6 dout in master serial", ser_dout, 1);
        ser_din = 1'b0;
        for (int i = 0; i < 100; i++) begin
            cyc(1);
            if (cclk_out && !last) rises++;
            last = cclk_out;
        end
        chk(!done && io_hiz && rises >= 40, "R4 not done after 100 cycles", rises, 50);
        wait_done(200, seen);
        chk(seen, "R4 master serial finishes", seen, 1);
        chk(!io_hiz && !pullup_en && !cclk_drive, "R9 released", io_hiz, 0);
    endtask

    task automatic t_slave_parallel_pu();
        bit seen;
        start_cfg(3'b110);
        chk(pullup_en && !cclk_drive, "R8 pull-up parallel", {pullup_en, cclk_drive}, 2'b10);
        mode_pins = 3'b000;   // change after sample; must be ignored
        ser_din = 1'b1; #1;
        chk(ser_dout == 1'b0, "R6 no dout in parallel", ser_dout, 0);
        ser_din = 1'b0;
        for (int i = 0; i < 7; i++) pulse_cclk();
        cyc(4);
        chk(!done && !cclk_drive && io_hiz, "R3 R5 not done after 7 bytes", done, 0);
        pulse_cclk();
        wait_done(10, seen);
        chk(seen, "R5 done on 8th byte", seen, 1);
        chk(pullup_en == 1'b0, "R8 pull-up off after release", pullup_en, 1'b0);
    endtask

    task automatic t_release_cycle();
        int hiz_low_cycles;
        start_cfg(3'b010);
        for (int i = 0; i < 7; i++) pulse_cclk();
        cclk_in = 1'b1;
        hiz_low_cycles = 0;
        for (int i = 0; i < 10 && !done; i++) begin
            cyc(1);
            if (!io_hiz && !done) hiz_low_cycles++;
        end
        cclk_in = 1'b0;
        chk(done && hiz_low_cycles == 1, "R9 one release cycle", hiz_low_cycles, 1);
    endtask

    task automatic t_slave_serial();
        bit seen;
        start_cfg(3'b111);
        chk(!pullup_en && !cclk_drive, "R8 no pull-up slave serial", pullup_en, 0);
        ser_din = 1'b1; #1;
        chk(ser_dout == 1'b1, "R6 dout follows din", ser_dout, 1);
        ser_din = 1'b0;
        for (int i = 0; i < 63; i++) pulse_cclk();
        cyc(4);
        chk(!done, "R6 not done after 63 bits", done, 0);
        pulse_cclk();
        wait_done(10, seen);
        chk(seen, "R6 done on 64th bit", seen, 1);
    endtask

    task automatic t_bscan();
        bit seen;
        start_cfg(3'b101);
        for (int i = 0; i < 70; i++) pulse_cclk();
        cyc(4);
        chk(!done && init_n && io_hiz, "R7 clock ignored in scan mode", done, 0);
        scan_load_done = 1'b1; cyc(1); scan_load_done = 1'b0;
        wait_done(10, seen);
        chk(seen, "R7 strobe ends load", seen, 1);
    endtask

    task automatic t_prog_user();
        @(negedge clk);
        prog_n = 1'b0;
        @(posedge clk); #1;
        chk(!done && !init_n, "R10 done drops", {done, init_n}, 0);
        cyc(2);
        prog_n = 1'b1;
        cyc(5);
        chk(!init_n && io_hiz, "R10 clear follows", init_n, 0);
    endtask

    task automatic t_abort();
        bit seen;
        start_cfg(3'b010);
        for (int i = 0; i < 5; i++) pulse_cclk();
        start_cfg(3'b010);
        for (int i = 0; i < 7; i++) pulse_cclk();
        cyc(4);
        chk(!done, "R11 count restarts after abort", done, 0);
        pulse_cclk();
        wait_done(10, seen);
        chk(seen, "R11 done after full frame", seen, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clear_len();
        t_master_serial();
        t_slave_parallel_pu();
        t_release_cycle();
        t_slave_serial();
        t_bscan();
        t_prog_user();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule